// File: doc/BRIEF.md
# Synchronous Flow-Through Byte-Write SRAM

A single-clock static RAM with registered inputs and a flow-through read path. On every rising clock edge the block captures the address, the write data, the write controls, the three chip-select inputs and the output enable. A write that is captured at one edge is committed to the storage array at the next edge, with no external write strobe. A read that is captured at an edge presents its word combinationally from the array during the following cycle. No output register sits on that path.

The word is made of four byte lanes of `LANE_W` bits each: 9 bits for a 36-bit word and 8 bits for a 32-bit word. Lanes are written through two levels of enable. A global-write input forces all four lanes. When it is not asserted, the per-lane enables act only while the byte-write strobe is low. The shared data bus is split into an input word, an output word and a drive enable, which the chip's pad ring turns into a tristate pin. The two low address bits arrive on a separate input so that an external burst counter can drive them.

Top module: `sram_ft_bw`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `dq_drive` is 0.
- R2: A read is captured at edge N. During the cycle after edge N, `dq_drive` is 1 and `dq_out` holds the stored word. No further register stage delays the word. A write to the same address at the edge before N is already visible.
- R3: When `gw_n` = 0 on a selected cycle, all four lanes take `dq_in`, whatever the values of `bwe_n` and `bw_n`.
- R4: When `gw_n` = 1 and `bwe_n` = 0, each `bw_n[i]` = 0 writes lane i. Lane i occupies bits [i*LANE_W +: LANE_W]. `bw_n[0]` is the lowest lane and `bw_n[3]` the highest.
- R5: When `gw_n` = 1 and `bwe_n` = 1, `bw_n` has no effect. The cycle is a read and the stored word is unchanged.
- R6: On a write, lanes that are not enabled keep their earlier contents.
- R7: A cycle is selected only when `ce_n` = 0, `ce2` = 1 and `ce2_n` = 0. Any other combination writes nothing, and `dq_drive` is 0 in the following cycle.
- R8: `oe_n` is registered with the other inputs. A selected read drives the bus in the next cycle only if `oe_n` was 0 at its capture edge.
- R9: In the cycle after a write is captured, `dq_drive` is 0.
- R10: The word address is {`addr_hi`, `addr_lo`}, with `addr_lo` as its two least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are captured on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the input registers |
| addr_hi | input | ADDR_W-2 | Upper word-address bits |
| addr_lo | input | 2 | Two low address bits, from an external burst counter |
| ce_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce2_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write, active low; writes all lanes |
| bwe_n | input | 1 | Byte-write strobe, active low; qualifies bw_n |
| bw_n | input | 4 | Per-lane write enables, active low; bit i is lane i |
| oe_n | input | 1 | Output enable, active low, registered |
| dq_in | input | 4*LANE_W | Write data from the bus pad |
| dq_out | output | 4*LANE_W | Read data to the bus pad; zero when not driving |
| dq_drive | output | 1 | Pad drive enable for dq_out |

## Verification
A wrong lane mask in the captured write controls does not show at once. It shows on the first read of that address, which may come many cycles later. The bench therefore reads each word back in the cycle right after each write, so that a lost, extra or shifted lane is caught one cycle after it is committed. A wrong select or enable decode shows in the very next cycle as an unexpected value on `dq_drive`. A read path with one register too many shows as a stale word at the first sample after a read.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;

    localparam int NUM_LANES = 4;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    // Two-level enable: the global write overrides, byte enables need the strobe
    function automatic logic [NUM_LANES-1:0] lane_write_mask(
        input logic                 gw_n,
        input logic                 bwe_n,
        input logic [NUM_LANES-1:0] bw_n
    );
        logic [NUM_LANES-1:0] m;
        if (!gw_n)       m = '1;
        else if (!bwe_n) m = ~bw_n;
        else             m = '0;
        return m;
    endfunction

endpackage

// File: rtl/ftsram_in_reg.sv
module ftsram_in_reg
    import ftsram_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6,
    localparam int WORD_W = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-3:0]    addr_hi,
    input  logic [1:0]           addr_lo,
    input  logic                 ce_n,
    input  logic                 ce2,
    input  logic                 ce2_n,
    input  logic                 gw_n,
    input  logic                 bwe_n,
    input  logic [NUM_LANES-1:0] bw_n,
    input  logic                 oe_n,
    input  logic [WORD_W-1:0]    dq_in,
    output cyc_kind_e            kind_o,
    output logic                 oe_o,
    output logic [NUM_LANES-1:0] mask_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [WORD_W-1:0]    data_o
);

    typedef struct packed {
        cyc_kind_e            kind;
        logic                 oe;
        logic [NUM_LANES-1:0] mask;
        logic [ADDR_W-1:0]    addr;
        logic [WORD_W-1:0]    data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        logic                 sel;
        logic [NUM_LANES-1:0] m;
        sel        = !ce_n && ce2 && !ce2_n;
        m          = lane_write_mask(gw_n, bwe_n, bw_n);
        cap_d      = cap_q;
        cap_d.addr = {addr_hi, addr_lo};
        cap_d.data = dq_in;
        cap_d.oe   = !oe_n;
        if (!sel) begin
            cap_d.kind = CYC_IDLE;
            cap_d.mask = '0;
        end else if (m != '0) begin
            cap_d.kind = CYC_WRITE;
            cap_d.mask = m;
        end else begin
            cap_d.kind = CYC_READ;
            cap_d.mask = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '{kind: CYC_IDLE, oe: 1'b0, mask: '0, addr: '0, data: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign kind_o = cap_q.kind;
    assign oe_o   = cap_q.oe;
    assign mask_o = cap_q.mask;
    assign addr_o = cap_q.addr;
    assign data_o = cap_q.data;

endmodule

// File: rtl/ftsram_lane.sv
module ftsram_lane #(
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);

    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Flow-through: no output register
    assign rdata = store[raddr];

endmodule

// File: rtl/sram_ft_bw.sv
module sram_ft_bw
    import ftsram_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6,
    localparam int WORD_W = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-3:0]    addr_hi,
    input  logic [1:0]           addr_lo,
    input  logic                 ce_n,
    input  logic                 ce2,
    input  logic                 ce2_n,
    input  logic                 gw_n,
    input  logic                 bwe_n,
    input  logic [NUM_LANES-1:0] bw_n,
    input  logic                 oe_n,
    input  logic [WORD_W-1:0]    dq_in,
    output logic [WORD_W-1:0]    dq_out,
    output logic                 dq_drive
);

    cyc_kind_e            kind_q;
    logic                 oe_q;
    logic [NUM_LANES-1:0] mask_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [WORD_W-1:0]    data_q;
    logic [WORD_W-1:0]    word_rd;

    ftsram_in_reg #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_in_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_hi (addr_hi),
        .addr_lo (addr_lo),
        .ce_n    (ce_n),
        .ce2     (ce2),
        .ce2_n   (ce2_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .oe_n    (oe_n),
        .dq_in   (dq_in),
        .kind_o  (kind_q),
        .oe_o    (oe_q),
        .mask_o  (mask_q),
        .addr_o  (addr_q),
        .data_o  (data_q)
    );

    // Write captured at edge N commits at edge N+1 (self-timed, no strobe)
    for (genvar li = 0; li < NUM_LANES; li++) begin : g_lane
        ftsram_lane #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_lane (
            .clk   (clk),
            .we    (kind_q == CYC_WRITE && mask_q[li]),
            .waddr (addr_q),
            .wdata (data_q[li*LANE_W +: LANE_W]),
            .raddr (addr_q),
            .rdata (word_rd[li*LANE_W +: LANE_W])
        );
    end

    assign dq_drive = (kind_q == CYC_READ) && oe_q;
    assign dq_out   = dq_drive ? word_rd : '0;

endmodule

// File: rtl/ftsram_chk.sv
module ftsram_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             ce2,
    input logic             ce2_n,
    input logic             gw_n,
    input logic             bwe_n,
    input logic [LANES-1:0] bw_n,
    input logic             oe_n,
    input logic             dq_drive
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !dq_drive);

    // R7
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n || !ce2 || ce2_n) |-> !dq_drive);

    // R9
    global_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!gw_n) |-> !dq_drive);

    // R8
    drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> $past(!oe_n));

    // R5
    drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> $past(gw_n && (bwe_n || (&bw_n))));

endmodule

bind sram_ft_bw ftsram_chk #(.LANES(ftsram_pkg::NUM_LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .ce2      (ce2),
    .ce2_n    (ce2_n),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bw_n     (bw_n),
    .oe_n     (oe_n),
    .dq_drive (dq_drive)
);

// File: tb/tb_sram_ft_bw.sv
module tb_sram_ft_bw;

    localparam int CLK_PERIOD = 10;
    localparam int LANE_W = 9;
    localparam int ADDR_W = 6;
    localparam int WORD_W = 4 * LANE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-3:0] addr_hi = '0;
    logic [1:0]        addr_lo = '0;
    logic              ce_n = 1'b1, ce2 = 1'b0, ce2_n = 1'b1;
    logic              gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
    logic [3:0]        bw_n = 4'hF;
    logic [WORD_W-1:0] dq_in = '0;
    logic [WORD_W-1:0] dq_out;
    logic              dq_drive;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ft_bw #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .addr_lo(addr_lo),
        .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out),
        .dq_drive(dq_drive)
    );

    typedef struct packed {
        logic [3:0]        req;
        logic [2:0]        ce;     // {ce_n, ce2, ce2_n}
        logic              oe_n;
        logic              gw_n;
        logic              bwe_n;
        logic [3:0]        bw_n;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] din;
        logic              exp_drv;
        logic [WORD_W-1:0] exp_q;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // R3 global write, no drive afterwards (R9)
        '{4'd3, 3'b010, 1'b0, 1'b0, 1'b1, 4'hF, 6'd5, 36'h123456789, 1'b0, 36'h0},
        // R2 flow-through read of the word just written
        '{4'd2, 3'b010, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 36'h0, 1'b1, 36'h123456789},
        // R4 lane 0 only
        '{4'd4, 3'b010, 1'b0, 1'b1, 1'b0, 4'b1110, 6'd5, 36'hFFFFFFFFF, 1'b0, 36'h0},
        // R6 other lanes kept
        '{4'd6, 3'b010, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 36'h0, 1'b1, 36'h1234567FF},
        // R4 lanes 2 and 3
        '{4'd4, 3'b010, 1'b0, 1'b1, 1'b0, 4'b0011, 6'd5, 36'h0, 1'b0, 36'h0},
        // R6 lanes 0 and 1 kept
        '{4'd6, 3'b010, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 36'h0, 1'b1, 36'h0000167FF},
        // R5 byte enables without strobe: read
        '{4'd5, 3'b010, 1'b0, 1'b1, 1'b1, 4'h0, 6'd5, 36'h0, 1'b1, 36'h0000167FF},
        // R5 word unchanged
        '{4'd5, 3'b010, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 36'h0, 1'b1, 36'h0000167FF},
        // R3 global write overrides strobe with no lanes
        '{4'd3, 3'b010, 1'b0, 1'b0, 1'b0, 4'hF, 6'd6, 36'hABCDEF012, 1'b0, 36'h0},
        '{4'd3, 3'b010, 1'b0, 1'b1, 1'b1, 4'hF, 6'd6, 36'h0, 1'b1, 36'hABCDEF012},
        // R7 ce_n high: write ignored
        '{4'd7, 3'b110, 1'b0, 1'b0, 1'b1, 4'hF, 6'd6, 36'h0, 1'b0, 36'h0},
        '{4'd7, 3'b010, 1'b0, 1'b1, 1'b1, 4'hF, 6'd6, 36'h0, 1'b1, 36'hABCDEF012},
        // R7 ce2 low
        '{4'd7, 3'b000, 1'b0, 1'b1, 1'b1, 4'hF, 6'd6, 36'h0, 1'b0, 36'h0},
        // R7 ce2_n high
        '{4'd7, 3'b011, 1'b0, 1'b1, 1'b1, 4'hF, 6'd6, 36'h0, 1'b0, 36'h0},
        // R8 oe_n high at read edge
        '{4'd8, 3'b010, 1'b1, 1'b1, 1'b1, 4'hF, 6'd6, 36'h0, 1'b0, 36'h0},
        // R10 low bits select word within group
        '{4'd10, 3'b010, 1'b0, 1'b0, 1'b1, 4'hF, 6'd39, 36'h0F0F0F0F0, 1'b0, 36'h0},
        '{4'd10, 3'b010, 1'b0, 1'b0, 1'b1, 4'hF, 6'd36, 36'h5A5A5A5A5, 1'b0, 36'h0},
        '{4'd10, 3'b010, 1'b0, 1'b1, 1'b1, 4'hF, 6'd39, 36'h0, 1'b1, 36'h0F0F0F0F0},
        '{4'd10, 3'b010, 1'b0, 1'b1, 1'b1, 4'hF, 6'd36, 36'h0, 1'b1, 36'h5A5A5A5A5},
        // R6 earlier word untouched
        '{4'd6, 3'b010, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 36'h0, 1'b1, 36'h0000167FF}
    };

    task automatic check(input int req, input logic exp_drv, input logic [WORD_W-1:0] exp_q);
        checks++;
        if (dq_drive !== exp_drv || (exp_drv && dq_out !== exp_q)) begin
            failures++;
            $display("FAIL R%0d: drive=%0b q=%h expected drive=%0b q=%h",
                     req, dq_drive, dq_out, exp_drv, exp_q);
        end
    endtask

    task automatic apply(input vec_t v);
        {ce_n, ce2, ce2_n} = v.ce;
        oe_n    = v.oe_n;
        gw_n    = v.gw_n;
        bwe_n   = v.bwe_n;
        bw_n    = v.bw_n;
        addr_hi = v.addr[ADDR_W-1:2];
        addr_lo = v.addr[1:0];
        dq_in   = v.din;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 no drive during reset
        check(1, 1'b0, '0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 first cycle after release
        check(1, 1'b0, '0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check(int'(VECS[i].req), VECS[i].exp_drv, VECS[i].exp_q);
        end

        // R1 reset captured at a read edge stops the drive
        rst_n = 1'b0;
        apply(VECS[19]);
        check(1, 1'b0, '0);
        rst_n = 1'b1;
        apply(VECS[19]);
        // R2 memory survives reset of the input registers
        check(2, 1'b1, 36'h0000167FF);

        // R9 back-to-back: byte write then read of same word
        apply('{4'd9, 3'b010, 1'b0, 1'b1, 1'b0, 4'b1101, 6'd5, 36'h000000000, 1'b0, 36'h0});
        check(9, 1'b0, '0);
        apply(VECS[19]);
        check(4, 1'b1, 36'h0000001FF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule